// File: doc/BRIEF.md
# Single-Character Printer Model

This block stands in for a slow character printer on the far side of a parallel output controller. It offers a ready line to its partner. When the partner raises a transfer request while the line is high, the model latches the byte on its data input, drops ready, and stays busy for a fixed number of clock cycles that represents the print time. When that time runs out, ready goes high again, and the latched byte appears on the printed-character output with a one-cycle strobe.

Only one character is held at a time. Requests that arrive while the model is busy have no effect. The print time is a parameter counted in clock cycles. The default corresponds to a print time of several milliseconds, and a test can set it much shorter. The block is meant to serve as the peripheral end when the output controller is verified.

Top module: `printer_model`

## Requirements
- R1: While reset is high and in the first cycle after it, `ready` is 1, `char_valid` is 0 and `char_out` is 0.
- R2: A rising clock edge that sees `ready` = 1 and `xfer_req` = 1 accepts the byte on `xfer_data`, and `ready` is 0 in the following cycle.
- R3: After an accepting edge, `ready` stays 0 for exactly `PRINT_CYCLES` clock cycles and then returns to 1.
- R4: `char_valid` is 1 for exactly one cycle, which is the first cycle in which `ready` is back at 1. In that cycle `char_out` equals the accepted byte. Each accepted byte yields exactly one strobe.
- R5: A request that arrives while `ready` is 0 is ignored. It adds no strobe, does not lengthen the busy time, and does not replace the byte being printed.
- R6: Outside the strobe cycle, `char_out` keeps the last printed byte.
- R7: If a request is pending as soon as `ready` returns, the next byte is accepted on the following edge. Consecutive prints are therefore `PRINT_CYCLES` + 1 cycles apart.
- R8: The byte that is printed is the value `xfer_data` held at the accepting edge. Changes to `xfer_data` after that edge do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Transfer request from the controller |
| xfer_data | input | DATA_W | Parallel byte offered with the request |
| ready | output | 1 | High when a new byte can be accepted |
| char_out | output | DATA_W | Last printed byte |
| char_valid | output | 1 | One-cycle strobe marking a completed print |

## Verification
The assertions assume that `xfer_req` and `xfer_data` change only away from the rising edge. They also assume that `PRINT_CYCLES` is at least 1. No assumption is made about how long a request is held or when it is raised. The property that limits the busy time therefore has to hold even when requests are raised during the busy time. The stimulus drives every input on the falling edge. It raises requests both while the model is ready and, on purpose, while it is busy. It also changes `xfer_data` right after each accepted byte.

// File: rtl/printer_pkg.sv
package printer_pkg;

    typedef enum logic [0:0] {
        PR_IDLE = 1'b0,
        PR_BUSY = 1'b1
    } pr_state_e;

    typedef struct packed {
        logic busy;
        logic done;
    } pr_timer_t;

    function automatic int unsigned pr_cnt_width(input int unsigned cycles);
        return (cycles <= 1) ? 1 : $clog2(cycles);
    endfunction

endpackage

// File: rtl/printer_timer.sv
module printer_timer
    import printer_pkg::*;
#(
    parameter int unsigned PRINT_CYCLES = 8,
    parameter int unsigned CNT_W        = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output pr_timer_t stat
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PRINT_CYCLES - 1);

    pr_state_e        state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PR_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                PR_IDLE: begin
                    if (start) begin
                        state <= PR_BUSY;
                        cnt   <= LOAD;
                    end
                end
                PR_BUSY: begin
                    if (cnt == '0) begin
                        state <= PR_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= PR_IDLE;
            endcase
        end
    end

    always_comb begin
        stat.busy = (state == PR_BUSY);
        stat.done = (state == PR_BUSY) && (cnt == '0);
    end
endmodule

// File: rtl/printer_accept.sv
module printer_accept #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ready,
    input  logic              xfer_req,
    input  logic [DATA_W-1:0] xfer_data,
    output logic              take,
    output logic [DATA_W-1:0] held
);
    assign take = ready & xfer_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (take) begin
            held <= xfer_data;
        end
    end
endmodule

// File: rtl/printer_emit.sv
module printer_emit #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [DATA_W-1:0] held,
    output logic [DATA_W-1:0] char_out,
    output logic              char_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            char_out   <= '0;
            char_valid <= 1'b0;
        end else begin
            char_valid <= done;
            if (done) begin
                char_out <= held;
            end
        end
    end
endmodule

// File: rtl/printer_model.sv
module printer_model
    import printer_pkg::*;
#(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned PRINT_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_req,
    input  logic [DATA_W-1:0] xfer_data,
    output logic              ready,
    output logic [DATA_W-1:0] char_out,
    output logic              char_valid
);
    localparam int unsigned CNT_W = pr_cnt_width(PRINT_CYCLES);

    pr_timer_t         tstat;
    logic              take;
    logic [DATA_W-1:0] held;

    assign ready = ~tstat.busy;

    printer_accept #(.DATA_W(DATA_W)) u_accept (
        .clk       (clk),
        .rst       (rst),
        .ready     (ready),
        .xfer_req  (xfer_req),
        .xfer_data (xfer_data),
        .take      (take),
        .held      (held)
    );

    printer_timer #(.PRINT_CYCLES(PRINT_CYCLES), .CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (take),
        .stat  (tstat)
    );

    printer_emit #(.DATA_W(DATA_W)) u_emit (
        .clk        (clk),
        .rst        (rst),
        .done       (tstat.done),
        .held       (held),
        .char_out   (char_out),
        .char_valid (char_valid)
    );
endmodule

// File: rtl/printer_model_chk.sv
module printer_model_chk #(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned PRINT_CYCLES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              xfer_req,
    input logic              ready,
    input logic [DATA_W-1:0] char_out,
    input logic              char_valid
);
    int unsigned low_cnt;

    always_ff @(posedge clk) begin
        if (rst)        low_cnt <= 0;
        else if (!ready) low_cnt <= low_cnt + 1;
        else            low_cnt <= 0;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (ready && !char_valid && char_out == '0));

    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (ready && xfer_req) |=> !ready);

    assert_fall_needs_request_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(xfer_req));

    assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (low_cnt < PRINT_CYCLES));

    assert_busy_exact_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (low_cnt == PRINT_CYCLES));

    assert_strobe_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> char_valid);

    assert_strobe_when_ready_R4: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> ready);

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> !char_valid);

    assert_hold_output_R6: assert property (@(posedge clk) disable iff (rst)
        !char_valid |-> $stable(char_out));
endmodule

bind printer_model printer_model_chk #(
    .DATA_W(DATA_W),
    .PRINT_CYCLES(PRINT_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .xfer_req   (xfer_req),
    .ready      (ready),
    .char_out   (char_out),
    .char_valid (char_valid)
);

// File: tb/printer_model_tb.sv
`timescale 1ns/1ps
module printer_model_tb;
    localparam int unsigned DW = 8;
    localparam int unsigned PC = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xfer_req = 1'b0;
    logic [DW-1:0] xfer_data = '0;
    logic          ready;
    logic [DW-1:0] char_out;
    logic          char_valid;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned cyc      = 0;
    bit          finished = 1'b0;

    typedef struct {
        logic [DW-1:0] data;
        int unsigned   at;
    } exp_t;
    exp_t sb[$];

    printer_model #(.DATA_W(DW), .PRINT_CYCLES(PC)) u_dut (
        .clk(clk), .rst(rst), .xfer_req(xfer_req), .xfer_data(xfer_data),
        .ready(ready), .char_out(char_out), .char_valid(char_valid)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: every strobe must match the oldest expected print (R4, R5, R8, R7)
    always @(negedge clk) begin
        if (!rst && char_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5 unexpected strobe", int'(char_out), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(char_out == e.data, "R4/R8 printed byte", int'(char_out), int'(e.data));
                check(cyc == e.at, "R7/R4 strobe cycle", int'(cyc), int'(e.at));
            end
        end
    end

    // Driver: offers one byte, optionally pokes requests while busy
    task automatic send(input logic [DW-1:0] d, input bit poke);
        int unsigned lows;
        exp_t e;
        while (!ready) @(negedge clk);
        xfer_req  = 1'b1;
        xfer_data = d;
        e.data = d;
        e.at   = cyc + 1 + PC;
        sb.push_back(e);
        @(negedge clk);
        xfer_req  = 1'b0;
        xfer_data = ~d;
        check(ready == 1'b0, "R2 ready after accept", int'(ready), 0);
        lows = 1;
        forever begin
            @(negedge clk);
            if (ready) begin
                xfer_req = 1'b0;
                break;
            end
            lows++;
            if (poke) begin
                xfer_req  = 1'b1;
                xfer_data = 8'hFF;
            end
        end
        check(lows == PC, "R3 busy length", int'(lows), int'(PC));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
        check(char_valid == 1'b0, "R1 strobe in reset", int'(char_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
        check(char_valid == 1'b0, "R1 strobe after reset", int'(char_valid), 0);
        check(char_out == '0, "R1 output after reset", int'(char_out), 0);

        send(8'hA5, 1'b0);
        repeat (2) @(negedge clk);

        send(8'h3C, 1'b1);
        repeat (4) @(negedge clk);
        check(char_out == 8'h3C, "R5/R6 output held", int'(char_out), 8'h3C);
        check(char_valid == 1'b0, "R6 no strobe while idle", int'(char_valid), 0);

        for (int i = 0; i < 4; i++) begin
            send(8'(8'h10 + i * 8'h21), 1'b0);
        end
        repeat (3) @(negedge clk);
        check(char_out == 8'h73, "R6 last byte held", int'(char_out), 8'h73);

        send(8'h00, 1'b1);
        send(8'hFF, 1'b0);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R4 all prints seen", sb.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule